// File: doc/BRIEF.md
# Edge-Pulse Signalling Link with Receive Watchdog

This block carries one logic level across a link using two pulse wires instead of a level wire. The sending half synchronises its input and watches for changes. Each change to high sends a one-cycle pulse on the set wire, and each change to low sends one on the clear wire. While the input is idle, the sending half repeats a pulse that matches the present level. These repeats keep the far side correct even if an earlier pulse was lost.

The receiving half keeps the level in a set/clear latch. It also runs a watchdog counter that every arriving pulse restarts. If pulses stop, the watchdog forces the output to a parameter-chosen default and raises a fault flag. The next pulse restores tracking. Both halves run on one clock, and all intervals are counted in cycles.

The two halves meet only at the top-level ports. The integrator wires `tx_set`/`tx_rst` to `rx_set`/`rx_rst`, directly or through any pulse-preserving path. A parameter check at elaboration rejects a watchdog interval too short to cover one refresh period plus the synchroniser delay.

Top module: `plink_top`

## Requirements
- R1: When `din` is first sampled at a new level on clock edge k, the sender drives exactly one pulse in the cycle after edge k+2. The pulse is on `tx_set` for a change to 1 and on `tx_rst` for a change to 0.
- R2: One edge after `rx_rst` is high, `dout` is 0. One edge after `rx_set` alone is high, `dout` is 1. With neither pulse present and no watchdog expiry, `dout` holds its value.
- R3: While the synchronised input stays still, the sender repeats a pulse every REFRESH_CYCLES cycles. The pulse is on `tx_set` if the level is 1 and on `tx_rst` if it is 0. Any edge pulse restarts this interval.
- R4: If WDOG_CYCLES clock edges pass with no pulse on either receive wire, then on the WDOG_CYCLES-th edge after the last pulse `dout` becomes DEFAULT_LEVEL and `link_fault` rises. Any pulse restarts the count.
- R5: Every sender pulse lasts exactly one cycle, and `tx_set` and `tx_rst` are never high together.
- R6: Any receive pulse clears `link_fault` on the following edge, and `dout` resumes following the pulses.
- R7: During and just after reset, `dout` equals DEFAULT_LEVEL, `link_fault` is 1, `collision` is 0, and both sender wires are 0. The sender then sends a pulse for the present input level on the third edge after reset is released.
- R8: If `rx_set` and `rx_rst` are high in the same cycle, `dout` becomes 0 and `collision` rises. `collision` then stays at 1 until reset.
- R9: With the sender looped back to the receiver and the input idle, `link_fault` never rises and `dout` follows `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Level to be carried; may be asynchronous |
| tx_set | output | 1 | Sender pulse: level is 1 |
| tx_rst | output | 1 | Sender pulse: level is 0 |
| rx_set | input | 1 | Receiver set pulse |
| rx_rst | input | 1 | Receiver clear pulse; wins a tie |
| dout | output | 1 | Recovered level |
| link_fault | output | 1 | High while the output is forced by the watchdog |
| collision | output | 1 | Sticky flag: both receive pulses seen together |

## Verification
A sender counter that is wrong shows up within one refresh period. The repeat pulse then arrives early, late or with the wrong polarity, so the bench measures the exact gap in cycles after each pulse. A watchdog count that is off by one moves the rise of `link_fault` away from the WDOG_CYCLES-th edge, and the bench samples that exact edge and the one before it. A latch that sits at the wrong value after a pulse, or a fault flag that does not clear, is visible at `dout` one edge after the pulse.

// File: rtl/pulse_link_pkg.sv
package pulse_link_pkg;
   typedef struct packed {
      logic set;
      logic clr;
   } plink_pulse_t;
endpackage

// File: rtl/plink_sync.sv
module plink_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ff_q <= '0;
      else        ff_q <= {ff_q[STAGES-2:0], d};
   end

   assign q = ff_q[STAGES-1];
endmodule

// File: rtl/plink_tx.sv
module plink_tx
   import pulse_link_pkg::*;
#(
   parameter int REFRESH_CYCLES = 100,
   parameter int SYNC_STAGES    = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         din,
   output plink_pulse_t pulse_o
);
   localparam int CW = $clog2(REFRESH_CYCLES);
   localparam logic [CW-1:0] CNT_LAST = CW'(REFRESH_CYCLES - 1);
   localparam int WW = $clog2(SYNC_STAGES + 1);
   localparam logic [WW-1:0] WARM_DONE = WW'(SYNC_STAGES);

   logic          lvl;
   logic          prev_q;
   logic          started_q;
   logic [WW-1:0] warm_q;
   logic [CW-1:0] cnt_q;
   plink_pulse_t  pulse_q;
   logic          is_edge, is_init, is_refresh, fire;

   plink_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (din),
      .q    (lvl)
   );

   always_comb begin
      is_edge    = started_q && (lvl != prev_q);
      is_init    = !started_q && (warm_q == WARM_DONE);
      is_refresh = started_q && (cnt_q == CNT_LAST);
      fire       = is_edge || is_init || is_refresh;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q    <= 1'b0;
         started_q <= 1'b0;
         warm_q    <= '0;
         cnt_q     <= '0;
         pulse_q   <= '0;
      end else begin
         prev_q <= lvl;
         if (!started_q && warm_q != WARM_DONE) warm_q <= warm_q + 1'b1;
         if (is_init) started_q <= 1'b1;
         pulse_q.set <= fire && lvl;
         pulse_q.clr <= fire && !lvl;
         if (fire)           cnt_q <= '0;
         else if (started_q) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign pulse_o = pulse_q;
endmodule

// File: rtl/plink_rx.sv
module plink_rx
   import pulse_link_pkg::*;
#(
   parameter int   WDOG_CYCLES   = 250,
   parameter logic DEFAULT_LEVEL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  plink_pulse_t pulse_i,
   output logic         dout,
   output logic         link_fault,
   output logic         collision
);
   localparam int CW = $clog2(WDOG_CYCLES);
   localparam logic [CW-1:0] WD_LAST = CW'(WDOG_CYCLES - 1);

   logic [CW-1:0] wd_q;
   logic          out_q, fault_q, coll_q;
   logic          got, expire;

   always_comb begin
      got    = pulse_i.set || pulse_i.clr;
      expire = !got && (wd_q == WD_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q   <= DEFAULT_LEVEL;
         fault_q <= 1'b1;
         coll_q  <= 1'b0;
         wd_q    <= '0;
      end else begin
         if (pulse_i.clr)      out_q <= 1'b0;
         else if (pulse_i.set) out_q <= 1'b1;
         else if (expire)      out_q <= DEFAULT_LEVEL;

         if (got)         fault_q <= 1'b0;
         else if (expire) fault_q <= 1'b1;

         coll_q <= coll_q | (pulse_i.set & pulse_i.clr);

         if (got)                 wd_q <= '0;
         else if (wd_q != WD_LAST) wd_q <= wd_q + 1'b1;
      end
   end

   assign dout       = out_q;
   assign link_fault = fault_q;
   assign collision  = coll_q;
endmodule

// File: rtl/plink_top.sv
module plink_top
   import pulse_link_pkg::*;
#(
   parameter int   REFRESH_CYCLES = 100,
   parameter int   WDOG_CYCLES    = 250,
   parameter int   SYNC_STAGES    = 2,
   parameter logic DEFAULT_LEVEL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic tx_set,
   output logic tx_rst,
   input  logic rx_set,
   input  logic rx_rst,
   output logic dout,
   output logic link_fault,
   output logic collision
);
   localparam int SEND_LATENCY = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("plink_top: SYNC_STAGES must be at least 2");
   end
   if (REFRESH_CYCLES < 4) begin : g_bad_refresh
      $error("plink_top: REFRESH_CYCLES must be at least 4");
   end
   if (WDOG_CYCLES <= REFRESH_CYCLES + SEND_LATENCY) begin : g_bad_wdog
      $error("plink_top: WDOG_CYCLES must exceed REFRESH_CYCLES plus send latency");
   end

   plink_pulse_t tx_p, rx_p;

   plink_tx #(
      .REFRESH_CYCLES(REFRESH_CYCLES),
      .SYNC_STAGES   (SYNC_STAGES)
   ) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (din),
      .pulse_o(tx_p)
   );

   assign tx_set   = tx_p.set;
   assign tx_rst   = tx_p.clr;
   assign rx_p.set = rx_set;
   assign rx_p.clr = rx_rst;

   plink_rx #(
      .WDOG_CYCLES  (WDOG_CYCLES),
      .DEFAULT_LEVEL(DEFAULT_LEVEL)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_i   (rx_p),
      .dout      (dout),
      .link_fault(link_fault),
      .collision (collision)
   );
endmodule

// File: rtl/plink_chk.sv
module plink_chk #(
   parameter logic DEFAULT_LEVEL = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic tx_set,
   input logic tx_rst,
   input logic rx_set,
   input logic rx_rst,
   input logic dout,
   input logic link_fault,
   input logic collision
);
   AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_set && tx_rst)); // R5
   AST_SET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_set |=> !tx_set); // R5
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rst |=> !tx_rst); // R5
   AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_set && !rx_rst) |=> dout); // R2
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |=> !dout); // R8
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_set && !rx_rst) |=> ($stable(dout) || link_fault)); // R2
   AST_FAULT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      link_fault |-> (dout == DEFAULT_LEVEL)); // R4
   AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_set || rx_rst) |=> !link_fault); // R6
   AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      collision |=> collision); // R8
   AST_COLL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_set && rx_rst) |=> collision); // R8
endmodule

bind plink_top plink_chk #(.DEFAULT_LEVEL(DEFAULT_LEVEL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_set    (tx_set),
   .tx_rst    (tx_rst),
   .rx_set    (rx_set),
   .rx_rst    (rx_rst),
   .dout      (dout),
   .link_fault(link_fault),
   .collision (collision)
);

// File: tb/tb_plink_top.sv
module tb_plink_top;
   localparam int   RC  = 100;
   localparam int   WC  = 250;
   localparam logic DEF = 1'b1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic din = 1'b0;
   logic loop_en = 1'b1;
   logic inj_s = 1'b0, inj_r = 1'b0;
   logic tx_set, tx_rst, rx_set, rx_rst, dout, link_fault, collision;
   int   total = 0, bad = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   assign rx_set = loop_en ? tx_set : inj_s;
   assign rx_rst = loop_en ? tx_rst : inj_r;

   plink_top #(
      .REFRESH_CYCLES(RC),
      .WDOG_CYCLES   (WC),
      .SYNC_STAGES   (2),
      .DEFAULT_LEVEL (DEF)
   ) dut (
      .clk(clk), .rst_n(rst_n), .din(din),
      .tx_set(tx_set), .tx_rst(tx_rst),
      .rx_set(rx_set), .rx_rst(rx_rst),
      .dout(dout), .link_fault(link_fault), .collision(collision)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Expect silence for n-1 cycles, then a pulse of polarity pol on the n-th.
   task automatic wait_pulse(input int n, input bit pol, input string tag);
      for (int i = 1; i <= n; i++) begin
         step();
         if (i < n)
            chk(!(tx_set || tx_rst), tag, {tx_set, tx_rst}, 0);
         else
            chk(tx_set == pol && tx_rst == !pol, tag, {tx_set, tx_rst}, {pol, !pol});
      end
   endtask

   task automatic t_reset();
      din = 1'b1;
      rst_n = 1'b0;
      repeat (3) step();
      chk(dout == DEF, "R7 dout in reset", dout, DEF);
      chk(link_fault == 1'b1, "R7 fault in reset", link_fault, 1);
      rst_n = 1'b1;
      chk(collision == 1'b0 && !tx_set && !tx_rst, "R7 quiet after reset",
          {collision, tx_set, tx_rst}, 0);
      wait_pulse(3, 1'b1, "R7 initial pulse");
      step();
      chk(dout == 1'b1 && link_fault == 1'b0, "R6 tracking after first pulse",
          {dout, link_fault}, 2);
   endtask

   task automatic t_edges();
      din = 1'b0;
      wait_pulse(3, 1'b0, "R1 falling edge");
      step();
      chk(!tx_set && !tx_rst, "R5 single cycle", {tx_set, tx_rst}, 0);
      chk(dout == 1'b0, "R2 clear latch", dout, 0);
      din = 1'b1;
      wait_pulse(3, 1'b1, "R1 rising edge");
      step();
      chk(dout == 1'b1, "R2 set latch", dout, 1);
   endtask

   task automatic t_refresh();
      wait_pulse(RC - 1, 1'b1, "R3 refresh high");
      wait_pulse(RC, 1'b1, "R3 second refresh high");
      repeat (10) step();
      din = 1'b0;
      wait_pulse(3, 1'b0, "R3 edge restarts");
      wait_pulse(RC, 1'b0, "R3 refresh low");
   endtask

   task automatic t_idle();
      bit ok = 1'b1;
      for (int i = 0; i < 3 * WC; i++) begin
         step();
         if (link_fault || dout != din) ok = 1'b0;
      end
      chk(ok, "R9 healthy idle link", {link_fault, dout}, {1'b0, din});
   endtask

   task automatic t_watchdog();
      int guard = 0;
      bit ok = 1'b1;
      while (!(tx_set || tx_rst) && guard < 2 * RC) begin
         step();
         guard++;
      end
      step();
      loop_en = 1'b0;
      for (int i = 1; i <= WC - 2; i++) begin
         step();
         if (link_fault || dout != 1'b0) ok = 1'b0;
      end
      chk(ok, "R2 hold without pulses", {link_fault, dout}, 0);
      inj_s = 1'b1;
      step();
      inj_s = 1'b0;
      chk(dout == 1'b1 && !link_fault, "R4 pulse restarts watchdog", {dout, link_fault}, 2);
      ok = 1'b1;
      for (int i = 1; i <= WC; i++) begin
         step();
         if (i < WC && (link_fault || dout != 1'b1)) ok = 1'b0;
      end
      chk(ok, "R4 no early timeout", 0, 0);
      chk(link_fault == 1'b1, "R4 timeout edge", link_fault, 1);
      inj_r = 1'b1;
      step();
      inj_r = 1'b0;
      chk(dout == 1'b0 && !link_fault, "R6 recovery", {dout, link_fault}, 0);
      for (int i = 1; i < WC; i++) step();
      chk(!link_fault && dout == 1'b0, "R4 one cycle before timeout", {link_fault, dout}, 0);
      step();
      chk(link_fault && dout == DEF, "R4 forced default", {link_fault, dout}, {1'b1, DEF});
   endtask

   task automatic t_collision();
      chk(collision == 1'b0, "R8 no collision yet", collision, 0);
      inj_s = 1'b1;
      inj_r = 1'b1;
      step();
      inj_s = 1'b0;
      inj_r = 1'b0;
      chk(dout == 1'b0 && collision, "R8 clear wins", {dout, collision}, 1);
      repeat (3) step();
      inj_s = 1'b1;
      step();
      inj_s = 1'b0;
      chk(dout == 1'b1 && collision, "R8 sticky flag", {dout, collision}, 3);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_edges();
      t_refresh();
      t_idle();
      t_watchdog();
      t_collision();
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule